// File: doc/BRIEF.md
# Command-Driven SPI Master Transfer Engine

This block executes one serial command at a time as an SPI master. A command carries a transmit word, a length-select bit, a delay-select bit and four chip-select levels. Once the block accepts a command, it drives the chip selects to the levels the command gives. It then shifts a word of 8 to 16 bits out on MOSI, most significant bit first, and collects the same number of bits from MISO. After the transfer it waits for a delay-after-transfer, releases the chip selects and pulses `done`. The received word is right-justified on `rx_data`.

Commands arrive on a valid/ready interface. `cmd_ready` is high only when the engine is idle, no mode fault is held and `ss_n` is high. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. A source that sees `cmd_ready` low must keep its command until it is taken. An offer made while the engine is busy is not taken and has no effect. The result side has no back-pressure: `rx_data` is valid while `done` is high, and it holds that value until the next command is accepted.

Word length and delay come from two global fields, `cfg_bits` and `cfg_dtl`, which the engine samples when it accepts a command. The engine is always master. If `ss_n` is pulled low, the engine raises a sticky mode fault and abandons the current command.

Top module: `spi_cmd_engine`

## Requirements
- R1: With `cmd_len_sel`=0 the transfer is exactly 8 bits, so SCK makes 8 rising edges.
- R2: With `cmd_len_sel`=1 the length comes from `cfg_bits`. Codes 4'b1000 to 4'b1111 give 8 to 15 bits, and code 4'b0000 gives 16 bits.
- R3: With `cmd_len_sel`=1, the reserved `cfg_bits` codes 4'b0001 to 4'b0111 give an 8-bit transfer.
- R4: With `cmd_dly_sel`=1 and `cfg_dtl`=D in the range 1 to 255, the delay after transfer is N=32·D clocks.
- R5: With `cmd_dly_sel`=1 and `cfg_dtl`=0, the delay is N=8192 clocks.
- R6: With `cmd_dly_sel`=0, the delay is N=17 clocks.
- R7: `pcs` takes the value of `cmd_pcs` on the accepting edge. It holds that value until the edge that raises `done`. At every other time it is 4'b1111, and any number of its bits may be low.
- R8: A clock edge that samples `ss_n` low sets `mode_fault`. The same edge aborts the command, stops SCK and returns `pcs` to 4'b1111, and no `done` follows. `mode_fault` stays set, and `cmd_ready` stays low, until `fault_clr` is high on an edge where `ss_n` is high.
- R9: `done` is high for exactly one clock. It rises 4·L+N clock edges after the accepting edge, where L is the word length and N is the delay.
- R10: SCK is low while idle and runs at the clock divided by 4. In each 4-clock bit period it is low for two clocks and high for two. MOSI carries the word most significant bit first and changes only as SCK falls. MISO is captured while SCK is high.
- R11: While `done` is high, `rx_data` holds the L received bits, right-justified, with the first bit received as the most significant of them and all upper bits zero.
- R12: A command offered while a transfer or delay is in progress is not accepted. It changes neither `pcs`, the timing of `done`, nor SCK activity afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_len_sel | input | 1 | 0: 8-bit word, 1: length from `cfg_bits` |
| cmd_dly_sel | input | 1 | 0: standard delay, 1: delay from `cfg_dtl` |
| cmd_pcs | input | 4 | Chip-select levels for this command |
| cmd_tx | input | 16 | Transmit word, right-justified |
| cfg_bits | input | 4 | Global word-length code |
| cfg_dtl | input | 8 | Global delay multiplier |
| ss_n | input | 1 | Slave-select input; low means mode fault |
| fault_clr | input | 1 | Clears the mode fault |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| pcs | output | 4 | Peripheral chip selects |
| rx_data | output | 16 | Received word, right-justified |
| done | output | 1 | One-clock pulse at the end of a command |
| mode_fault | output | 1 | Sticky mode-fault flag |

## Verification
`done` is due 4·L+N edges after the accepting edge. The bench counts falling clock edges from that edge and expects `done` on count 4·L+N+1, and it checks `pcs` on every falling edge before then. A fault caused by `ss_n` low at one falling edge must show at the next falling edge, and the clear shows in the same way one edge after `fault_clr`. The bench compares serial data by counting SCK rising edges and assembling MOSI at those edges. A slave model shifts MISO on SCK falling edges, so received data is compared against the pattern masked to L bits.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/spi_len_decode.sv
module spi_len_decode #(
  parameter int DATA_W  = 16,
  parameter int BITS_W  = 4,
  parameter int MIN_LEN = 8,
  parameter int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              len_sel,
  input  logic [BITS_W-1:0] bits_code,
  output logic [LEN_W-1:0]  word_len
);

  always_comb begin
    word_len = LEN_W'(MIN_LEN);
    if (len_sel) begin
      if (bits_code == '0)
        word_len = LEN_W'(DATA_W);
      else if (bits_code >= BITS_W'(MIN_LEN))
        word_len = LEN_W'(bits_code);
    end
  end

endmodule

// File: rtl/spi_dly_decode.sv
module spi_dly_decode #(
  parameter int DTL_W     = 8,
  parameter int DTL_SCALE = 32,
  parameter int STD_DLY   = 17,
  parameter int ZERO_DLY  = 8192,
  parameter int CNT_W     = 14
) (
  input  logic             dly_sel,
  input  logic [DTL_W-1:0] dtl,
  output logic [CNT_W-1:0] dly_len
);

  always_comb begin
    if (!dly_sel)
      dly_len = CNT_W'(STD_DLY);
    else if (dtl == '0)
      dly_len = CNT_W'(ZERO_DLY);
    else
      dly_len = CNT_W'(dtl) * CNT_W'(DTL_SCALE);
  end

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              shift_tick,
  input  logic              sample_tick,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);

  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (load) begin
      tx_sh_q <= tx_word << (DATA_W - int'(word_len));
      rx_sh_q <= '0;
    end else begin
      if (shift_tick)
        tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
      if (sample_tick)
        rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
    end
  end

  assign mosi    = tx_sh_q[DATA_W-1];
  assign rx_word = rx_sh_q;

endmodule

// File: rtl/spi_dly_timer.sv
module spi_dly_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             abort,
  input  logic [CNT_W-1:0] dly_len,
  output logic             expired
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      run_q <= 1'b1;
      cnt_q <= dly_len - CNT_W'(1);
    end else if (run_q) begin
      if (cnt_q == '0)
        run_q <= 1'b0;
      else
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = run_q && (cnt_q == '0);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BITS_W    = 4,
  parameter int DTL_W     = 8,
  parameter int PCS_W     = 4,
  parameter int CLK_DIV   = 4,
  parameter int MIN_LEN   = 8,
  parameter int DTL_SCALE = 32,
  parameter int STD_DLY   = 17,
  parameter int ZERO_DLY  = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_len_sel,
  input  logic              cmd_dly_sel,
  input  logic [PCS_W-1:0]  cmd_pcs,
  input  logic [DATA_W-1:0] cmd_tx,
  input  logic [BITS_W-1:0] cfg_bits,
  input  logic [DTL_W-1:0]  cfg_dtl,
  input  logic              ss_n,
  input  logic              fault_clr,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [PCS_W-1:0]  pcs,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              mode_fault
);

  localparam int LEN_W      = $clog2(DATA_W + 1);
  localparam int SCALED_MAX = DTL_SCALE * ((1 << DTL_W) - 1);
  localparam int BIG_DLY    = (ZERO_DLY > SCALED_MAX) ? ZERO_DLY : SCALED_MAX;
  localparam int MAX_DLY    = (BIG_DLY > STD_DLY) ? BIG_DLY : STD_DLY;
  localparam int CNT_W      = $clog2(MAX_DLY + 1);
  localparam int DIV_W      = $clog2(CLK_DIV);
  localparam int HALF_DIV   = CLK_DIV / 2;

  xfer_state_e       state_q;
  logic [DIV_W-1:0]  ph_q;
  logic [LEN_W-1:0]  left_q;
  logic [PCS_W-1:0]  pcs_q;
  logic [CNT_W-1:0]  dly_q;
  logic              fault_q;
  logic              done_q;

  logic [LEN_W-1:0]  len_req;
  logic [CNT_W-1:0]  dly_req;
  logic              accept;
  logic              fault_set;
  logic              ph_last;
  logic              ph_smp;
  logic              shift_tick;
  logic              sample_tick;
  logic              last_bit;
  logic              tmr_load;
  logic              tmr_exp;

  spi_len_decode #(
    .DATA_W (DATA_W),
    .BITS_W (BITS_W),
    .MIN_LEN(MIN_LEN),
    .LEN_W  (LEN_W)
  ) u_len (
    .len_sel  (cmd_len_sel),
    .bits_code(cfg_bits),
    .word_len (len_req)
  );

  spi_dly_decode #(
    .DTL_W    (DTL_W),
    .DTL_SCALE(DTL_SCALE),
    .STD_DLY  (STD_DLY),
    .ZERO_DLY (ZERO_DLY),
    .CNT_W    (CNT_W)
  ) u_dly (
    .dly_sel(cmd_dly_sel),
    .dtl    (cfg_dtl),
    .dly_len(dly_req)
  );

  assign cmd_ready   = (state_q == ST_IDLE) && !fault_q && ss_n;
  assign accept      = cmd_valid && cmd_ready;
  assign fault_set   = !ss_n;
  assign ph_last     = (ph_q == DIV_W'(CLK_DIV - 1));
  assign ph_smp      = (ph_q == DIV_W'(HALF_DIV));
  assign shift_tick  = (state_q == ST_SHIFT) && ph_last;
  assign sample_tick = (state_q == ST_SHIFT) && ph_smp;
  assign last_bit    = (left_q == LEN_W'(1));
  assign tmr_load    = shift_tick && last_bit && !fault_set;

  spi_shift_unit #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .word_len   (len_req),
    .tx_word    (cmd_tx),
    .shift_tick (shift_tick),
    .sample_tick(sample_tick),
    .miso       (miso),
    .mosi       (mosi),
    .rx_word    (rx_data)
  );

  spi_dly_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .abort  (fault_set),
    .dly_len(dly_q),
    .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      left_q  <= '0;
      pcs_q   <= '1;
      dly_q   <= '0;
      fault_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fault_set)
        fault_q <= 1'b1;
      else if (fault_clr)
        fault_q <= 1'b0;

      if (fault_set) begin
        state_q <= ST_IDLE;
        ph_q    <= '0;
        left_q  <= '0;
        pcs_q   <= '1;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (accept) begin
              state_q <= ST_SHIFT;
              ph_q    <= '0;
              left_q  <= len_req;
              pcs_q   <= cmd_pcs;
              dly_q   <= dly_req;
            end
          end
          ST_SHIFT: begin
            if (ph_last) begin
              ph_q   <= '0;
              left_q <= left_q - LEN_W'(1);
              if (last_bit)
                state_q <= ST_HOLD;
            end else begin
              ph_q <= ph_q + DIV_W'(1);
            end
          end
          ST_HOLD: begin
            if (tmr_exp) begin
              state_q <= ST_IDLE;
              pcs_q   <= '1;
              done_q  <= 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sck        = (state_q == ST_SHIFT) && (ph_q >= DIV_W'(HALF_DIV));
  assign pcs        = pcs_q;
  assign done       = done_q;
  assign mode_fault = fault_q;

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int PCS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [PCS_W-1:0] cmd_pcs,
  input logic             ss_n,
  input logic             fault_clr,
  input logic             sck,
  input logic [PCS_W-1:0] pcs,
  input logic             done,
  input logic             mode_fault
);

  AST_IDLE_PCS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (pcs == '1)); // R7

  AST_ACCEPT_DRIVES_PCS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (pcs == $past(cmd_pcs))); // R7

  AST_PCS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !mode_fault) |=> (cmd_ready || mode_fault || $stable(pcs))); // R7

  AST_SS_LOW_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |=> mode_fault); // R8

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && !fault_clr) |=> mode_fault); // R8

  AST_FAULT_RELEASES_PCS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> ((pcs == '1) && !sck && !cmd_ready)); // R8

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !sck); // R10

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PCS_W(PCS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_pcs   (cmd_pcs),
  .ss_n      (ss_n),
  .fault_clr (fault_clr),
  .sck       (sck),
  .pcs       (pcs),
  .done      (done),
  .mode_fault(mode_fault)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_len_sel = 1'b0;
  logic        cmd_dly_sel = 1'b0;
  logic [3:0]  cmd_pcs = 4'hF;
  logic [15:0] cmd_tx = '0;
  logic [3:0]  cfg_bits = '0;
  logic [7:0]  cfg_dtl = '0;
  logic        ss_n = 1'b1;
  logic        fault_clr = 1'b0;
  logic        miso;
  logic        sck;
  logic        mosi;
  logic [3:0]  pcs;
  logic [15:0] rx_data;
  logic        done;
  logic        mode_fault;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] slv = '0;
  logic [15:0] mcap = '0;
  int          nrise = 0;

  always #5 clk = ~clk;

  spi_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len_sel(cmd_len_sel), .cmd_dly_sel(cmd_dly_sel), .cmd_pcs(cmd_pcs),
    .cmd_tx(cmd_tx), .cfg_bits(cfg_bits), .cfg_dtl(cfg_dtl), .ss_n(ss_n),
    .fault_clr(fault_clr), .miso(miso), .sck(sck), .mosi(mosi), .pcs(pcs),
    .rx_data(rx_data), .done(done), .mode_fault(mode_fault)
  );

  // slave model: MISO shifts on SCK falling edges, MOSI captured on rising edges
  assign miso = slv[15];
  always @(negedge sck) slv <= slv << 1;
  always @(posedge sck) begin
    mcap  <= {mcap[14:0], mosi};
    nrise <= nrise + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input bit lsel, input logic [3:0] b);
    if (!lsel) return 8;
    if (b == 4'd0) return 16;
    if (b < 4'd8) return 8;
    return int'(b);
  endfunction

  function automatic int exp_dly(input bit dsel, input logic [7:0] d);
    if (!dsel) return 17;
    if (d == 8'd0) return 8192;
    return 32 * int'(d);
  endfunction

  function automatic string len_tag(input bit lsel, input logic [3:0] b);
    if (!lsel) return "R1";
    if (b != 4'd0 && b < 4'd8) return "R3";
    return "R2";
  endfunction

  function automatic string dly_tag(input bit dsel, input logic [7:0] d);
    if (!dsel) return "R6";
    if (d == 8'd0) return "R5";
    return "R4";
  endfunction

  task automatic run_cmd(input bit lsel, input bit dsel, input logic [3:0] p,
                         input logic [15:0] tx, input logic [3:0] b,
                         input logic [7:0] d, input logic [15:0] pat,
                         input bit inject);
    int L, N, t, base;
    bit pcs_ok;
    logic [15:0] mask;
    L    = exp_len(lsel, b);
    N    = exp_dly(dsel, d);
    mask = (L == 16) ? 16'hFFFF : ((16'h1 << L) - 16'h1);
    @(negedge clk);
    cfg_bits = b; cfg_dtl = d;
    cmd_len_sel = lsel; cmd_dly_sel = dsel; cmd_pcs = p; cmd_tx = tx;
    cmd_valid = 1'b1;
    slv = pat << (16 - L);
    mcap = '0; nrise = 0;
    check(cmd_ready === 1'b1, "R7", "ready when idle", cmd_ready, 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 1;
    pcs_ok = 1'b1;
    while (!done && t < 20000) begin
      if (pcs !== p) pcs_ok = 1'b0;
      if (inject && t == 4) begin
        cmd_valid = 1'b1; cmd_pcs = ~p; cmd_tx = ~tx;
      end
      if (inject && t == 5) cmd_valid = 1'b0;
      @(negedge clk);
      t++;
    end
    check(t - 1 == 4 * L + N, dly_tag(dsel, d), "edges from accept to done",
          t - 1, 4 * L + N);
    check(pcs_ok, "R7", "pcs held during command", pcs_ok, 1);
    check(nrise == L, len_tag(lsel, b), "sck rising edges", nrise, L);
    check((mcap & mask) == (tx & mask), "R10", "mosi word", mcap & mask, tx & mask);
    check(rx_data == (pat & mask), "R11", "rx word", rx_data, pat & mask);
    check(pcs == 4'hF, "R7", "pcs released at done", pcs, 4'hF);
    @(negedge clk);
    check(done == 1'b0, "R9", "done one clock", done, 0);
    if (inject) begin
      base = nrise;
      for (int k = 0; k < 12; k++) begin
        check(pcs == 4'hF && !sck && !done, "R12", "busy offer ignored",
              {pcs, sck, done}, {4'hF, 1'b0, 1'b0});
        @(negedge clk);
      end
      check(nrise == base, "R12", "no sck after ignored offer", nrise, base);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(cmd_ready == 1'b1, "R7", "reset ready", cmd_ready, 1);
    check(pcs == 4'hF, "R7", "reset pcs", pcs, 4'hF);
    check(sck == 1'b0, "R10", "reset sck", sck, 0);
    check(done == 1'b0, "R9", "reset done", done, 0);
    check(mode_fault == 1'b0, "R8", "reset fault", mode_fault, 0);
    check(rx_data == 16'h0, "R11", "reset rx", rx_data, 0);

    // directed corners
    run_cmd(1'b0, 1'b0, 4'b1110, 16'h00A5, 4'b1100, 8'd3, 16'h003C, 1'b0); // R1 R6
    run_cmd(1'b1, 1'b1, 4'b0110, 16'hBEEF, 4'b0000, 8'd1, 16'hC3A5, 1'b0); // R2 16 bits R4
    run_cmd(1'b1, 1'b1, 4'b1011, 16'h1234, 4'b0011, 8'd255, 16'h00F1, 1'b0); // R3 R4 max
    run_cmd(1'b1, 1'b1, 4'b0000, 16'h01FF, 4'b1001, 8'd0, 16'h0155, 1'b0); // R2 9 bits R5
    run_cmd(1'b1, 1'b0, 4'b0101, 16'h7FFF, 4'b1111, 8'd9, 16'h5A5A, 1'b1); // R2 15 R12
    run_cmd(1'b1, 1'b0, 4'b1101, 16'h00FF, 4'b0111, 8'd0, 16'h0081, 1'b0); // R3 upper reserved R6

    // constrained random
    for (int i = 0; i < 30; i++) begin
      logic [3:0] rb;
      logic [7:0] rd;
      rb = 4'($urandom_range(0, 15));
      rd = 8'($urandom_range(1, 7));
      run_cmd(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              4'($urandom), 16'($urandom), rb, rd, 16'($urandom),
              1'($urandom_range(0, 3) == 0));
    end

    // mode fault in the middle of a transfer
    @(negedge clk);
    cfg_bits = 4'b0000; cfg_dtl = 8'd4;
    cmd_len_sel = 1'b1; cmd_dly_sel = 1'b1; cmd_pcs = 4'b0010; cmd_tx = 16'hA5A5;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (9) @(negedge clk);
    check(pcs == 4'b0010, "R7", "pcs before fault", pcs, 4'b0010);
    ss_n = 1'b0;
    @(negedge clk);
    ss_n = 1'b1;
    check(mode_fault == 1'b1, "R8", "fault set", mode_fault, 1);
    check(pcs == 4'hF, "R8", "pcs released on fault", pcs, 4'hF);
    check(cmd_ready == 1'b0, "R8", "ready low in fault", cmd_ready, 0);
    check(sck == 1'b0, "R8", "sck stopped on fault", sck, 0);
    cmd_valid = 1'b1; cmd_pcs = 4'b0001;
    t = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (done || pcs != 4'hF || sck) t++;
    end
    check(t == 0, "R8", "no done, pcs or sck after abort", t, 0);
    check(mode_fault == 1'b1, "R8", "fault sticky", mode_fault, 1);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    check(mode_fault == 1'b0, "R8", "fault cleared", mode_fault, 0);
    check(cmd_ready == 1'b1, "R8", "ready after clear", cmd_ready, 1);
    run_cmd(1'b1, 1'b0, 4'b1001, 16'h0C3C, 4'b1010, 8'd2, 16'h02D4, 1'b0); // recovery R2

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule